// File: doc/BRIEF.md
# Branch Target Buffer with Last-Outcome Direction Prediction

This block is a direct-mapped table of branches that have already run. The fetch stage gives it the PC it is about to fetch. The block answers with three things: whether that PC is a known branch, which way it is expected to go, and which PC to fetch next. The direction guess is simply the outcome the branch had the last time it completed. When the guess is taken, the next fetch address is the taken target stored in the table. In every other case it is the sequential address PC + 4.

Training comes from the branch-completion stage. Each instruction carries a flag saying whether it hit in the table at fetch, and that flag picks the kind of write. An instruction that missed at fetch claims its slot: the slot gets the valid bit, the tag, the branch kind, the taken target and the actual outcome. An instruction that hit at fetch touches only its outcome bit, and only when the new outcome differs from the stored one.

Instruction addresses are word aligned, so the two lowest PC bits are ignored. The next IDX_W bits select the slot, and the remaining upper bits are the tag. Lookups are registered: a PC sampled at one clock edge yields its answer after that edge.

Top module: `btb_predictor`

## Requirements
- R1: Reset clears every valid bit. After reset, each lookup reports a miss with a next fetch PC of PC + 4, and `pred_valid_o` stays low while reset is held.
- R2: The slot index is `pc[IDX_W+1:2]` and the tag is `pc[PC_W-1:IDX_W+2]`. Two PCs that share an index but differ in tag never hit on each other's entry.
- R3: `pred_hit_o` is high only when the indexed slot is valid and its stored tag equals the tag of the looked-up PC.
- R4: On a hit, `pred_taken_o` equals the stored last outcome and `pred_type_o` equals the stored branch kind. On a miss, both are 0.
- R5: `pred_next_pc_o` is the stored target when the prediction is a taken hit. Otherwise it is PC + 4, wrapping modulo 2^PC_W.
- R6: A lookup sampled with `fetch_valid_i` high at a rising edge has its result on the outputs after that edge, with `pred_valid_o` high. `pred_valid_o` is low after an edge where `fetch_valid_i` was low.
- R7: An update with `upd_fetch_hit_i` low writes the whole slot (valid, tag, kind, target, outcome). This replaces any entry with another tag that was in that slot.
- R8: An update with `upd_fetch_hit_i` high leaves the tag, kind and target of the slot unchanged and sets only its outcome bit.
- R9: An update and a lookup of the same slot in one cycle: the lookup returns the contents from before the update.
- R10: While `upd_valid_i` is low, the update fields have no effect on the table.
- R11: A stored outcome bit changes only through a write to that slot. A hit-flag update whose outcome equals the stored one leaves the slot as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | A lookup is requested this cycle |
| fetch_pc_i | input | PC_W | PC being fetched |
| pred_valid_o | output | 1 | Lookup result present |
| pred_hit_o | output | 1 | Fetched PC is a known branch |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| pred_type_o | output | TYPE_W | Stored branch kind on a hit, else 0 |
| pred_next_pc_o | output | PC_W | Predicted next fetch PC |
| upd_valid_i | input | 1 | A completed branch is presented |
| upd_pc_i | input | PC_W | PC of the completed branch |
| upd_type_i | input | TYPE_W | Branch kind to record |
| upd_target_i | input | PC_W | Taken target of the branch |
| upd_taken_i | input | 1 | Actual outcome (1 = taken) |
| upd_fetch_hit_i | input | 1 | Hit flag recorded for this branch at fetch |

## Verification
A corrupted tag or valid bit shows up as a wrong hit flag on the first lookup of that slot. A stale outcome bit shows up as a wrong direction, and when a taken guess is involved also as a wrong next PC, one cycle after that lookup. A hit-flag update that wrongly rewrote the payload would surface as a changed target or kind on the next lookup. A write that landed in the wrong slot would be seen as a false hit or a lost entry at that slot's next lookup. The bench therefore follows every kind of update with a lookup of the slot it touched, of an aliasing PC and of the same slot in the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Word-aligned instructions: two low PC bits carry no information.
  localparam int ALIGN_BITS = 2;
  localparam int INSN_BYTES = 4;

  // Kind of table write chosen for a completed branch.
  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_FILL = 2'd1,
    UPD_FLIP = 2'd2
  } upd_kind_e;

endpackage

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
  import btb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd_valid_i,
  input  logic upd_fetch_hit_i,
  input  logic upd_taken_i,
  input  logic cur_out_i,
  output logic pay_we_o,
  output logic out_we_o
);

  upd_kind_e kind;

  always_comb begin
    kind = UPD_IDLE;
    if (upd_valid_i) begin
      if (!upd_fetch_hit_i)
        kind = UPD_FILL;
      else if (cur_out_i != upd_taken_i)
        kind = UPD_FLIP;
    end
  end

  assign pay_we_o = (kind == UPD_FILL);
  assign out_we_o = (kind == UPD_FILL) || (kind == UPD_FLIP);

  // R10: no table write without a presented branch
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !upd_valid_i |-> (!pay_we_o && !out_we_o));

  // R8: a branch that hit at fetch never rewrites the payload
  a_r8_hit_keeps_payload: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_i && upd_fetch_hit_i) |-> !pay_we_o);

endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int IDX_W = 6,
  parameter int PAY_W = 58
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             pay_we_i,
  input  logic             out_we_i,
  input  logic [PAY_W-1:0] wr_pay_i,
  input  logic             wr_out_i,
  output logic             cur_out_o,
  output logic             ent_vld_o,
  output logic             ent_out_o,
  output logic [PAY_W-1:0] ent_pay_o
);

  localparam int DEPTH = 1 << IDX_W;

  // Payload RAM: tag, kind, target. No reset, one write port and one
  // registered read port, so it can map onto block RAM.
  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [PAY_W-1:0] pay_rd_q;

  always_ff @(posedge clk) begin
    if (pay_we_i)
      pay_mem[wr_idx_i] <= wr_pay_i;
    pay_rd_q <= pay_mem[rd_idx_i];
  end

  assign ent_pay_o = pay_rd_q;

  // Valid and outcome bits live in flops: resettable, and the outcome
  // needs a second read port for the update-side comparison.
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] out_q;
  logic             vld_rd_q;
  logic             out_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      out_q <= '0;
    end else begin
      if (pay_we_i)
        vld_q[wr_idx_i] <= 1'b1;
      if (out_we_i)
        out_q[wr_idx_i] <= wr_out_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_rd_q <= 1'b0;
      out_rd_q <= 1'b0;
    end else begin
      vld_rd_q <= vld_q[rd_idx_i];
      out_rd_q <= out_q[rd_idx_i];
    end
  end

  assign ent_vld_o = vld_rd_q;
  assign ent_out_o = out_rd_q;
  assign cur_out_o = out_q[wr_idx_i];

  // R1: reset leaves no slot valid
  a_r1_reset_clears_valid: assert property (@(posedge clk)
    $past(rst) |-> (vld_q == '0));

  // R7: a fill marks its slot valid
  a_r7_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    pay_we_i |=> vld_q[$past(wr_idx_i)]);

  // R11: an outcome bit moves only when its own slot is written
  for (genvar e = 0; e < DEPTH; e++) begin : g_out_chk
    a_r11_out_write_only: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_q[e]) |-> ($past(out_we_i) && ($past(wr_idx_i) == IDX_W'(e))));
  end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int TYPE_W = 2
) (
  input  logic [PC_W-1:0]                          pc_q_i,
  input  logic                                     ent_vld_i,
  input  logic                                     ent_out_i,
  input  logic [PC_W-IDX_W-2+TYPE_W+PC_W-1:0]      ent_pay_i,
  output logic                                     hit_o,
  output logic                                     taken_o,
  output logic [TYPE_W-1:0]                        type_o,
  output logic [PC_W-1:0]                          next_pc_o
);

  import btb_pkg::*;

  localparam int TAG_W = PC_W - IDX_W - ALIGN_BITS;

  logic [TAG_W-1:0]  ent_tag;
  logic [TYPE_W-1:0] ent_type;
  logic [PC_W-1:0]   ent_tgt;
  logic [TAG_W-1:0]  pc_tag;

  assign {ent_tag, ent_type, ent_tgt} = ent_pay_i;
  assign pc_tag = pc_q_i[PC_W-1:IDX_W+ALIGN_BITS];

  always_comb begin
    hit_o     = ent_vld_i && (ent_tag == pc_tag);
    taken_o   = hit_o && ent_out_i;
    type_o    = hit_o ? ent_type : '0;
    next_pc_o = taken_o ? ent_tgt : (pc_q_i + PC_W'(INSN_BYTES));
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  output logic              pred_valid_o,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [TYPE_W-1:0] pred_type_o,
  output logic [PC_W-1:0]   pred_next_pc_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [TYPE_W-1:0] upd_type_i,
  input  logic [PC_W-1:0]   upd_target_i,
  input  logic              upd_taken_i,
  input  logic              upd_fetch_hit_i
);

  import btb_pkg::*;

  localparam int TAG_W = PC_W - IDX_W - ALIGN_BITS;
  localparam int PAY_W = TAG_W + TYPE_W + PC_W;

  logic [IDX_W-1:0] fetch_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [TAG_W-1:0] upd_tag;
  logic             unused_align;

  assign fetch_idx    = fetch_pc_i[IDX_W+ALIGN_BITS-1:ALIGN_BITS];
  assign upd_idx      = upd_pc_i[IDX_W+ALIGN_BITS-1:ALIGN_BITS];
  assign upd_tag      = upd_pc_i[PC_W-1:IDX_W+ALIGN_BITS];
  assign unused_align = ^{fetch_pc_i[ALIGN_BITS-1:0], upd_pc_i[ALIGN_BITS-1:0],
                          fetch_pc_i[PC_W-1:IDX_W+ALIGN_BITS]};

  // Lookup stage registers, aligned with the RAM read.
  logic            look_v_q;
  logic [PC_W-1:0] look_pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      look_v_q  <= 1'b0;
      look_pc_q <= '0;
    end else begin
      look_v_q  <= fetch_valid_i;
      look_pc_q <= fetch_pc_i;
    end
  end

  logic             pay_we;
  logic             out_we;
  logic             cur_out;
  logic             ent_vld;
  logic             ent_out;
  logic [PAY_W-1:0] ent_pay;

  btb_update_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .upd_valid_i     (upd_valid_i),
    .upd_fetch_hit_i (upd_fetch_hit_i),
    .upd_taken_i     (upd_taken_i),
    .cur_out_i       (cur_out),
    .pay_we_o        (pay_we),
    .out_we_o        (out_we)
  );

  btb_store #(.IDX_W(IDX_W), .PAY_W(PAY_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd_idx_i  (fetch_idx),
    .wr_idx_i  (upd_idx),
    .pay_we_i  (pay_we),
    .out_we_i  (out_we),
    .wr_pay_i  ({upd_tag, upd_type_i, upd_target_i}),
    .wr_out_i  (upd_taken_i),
    .cur_out_o (cur_out),
    .ent_vld_o (ent_vld),
    .ent_out_o (ent_out),
    .ent_pay_o (ent_pay)
  );

  btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W), .TYPE_W(TYPE_W)) u_lookup (
    .pc_q_i    (look_pc_q),
    .ent_vld_i (ent_vld),
    .ent_out_i (ent_out),
    .ent_pay_i (ent_pay),
    .hit_o     (pred_hit_o),
    .taken_o   (pred_taken_o),
    .type_o    (pred_type_o),
    .next_pc_o (pred_next_pc_o)
  );

  assign pred_valid_o = look_v_q;

  // R6: result valid exactly one edge after the request
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_valid_i |=> pred_valid_o);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_i |=> !pred_valid_o);

  // R4: a taken guess only comes from a hit
  a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
    pred_taken_o |-> pred_hit_o);

  // R5: without a taken guess, fetch proceeds sequentially
  a_r5_sequential_next: assert property (@(posedge clk) disable iff (rst)
    !pred_taken_o |-> (pred_next_pc_o == look_pc_q + PC_W'(INSN_BYTES)));

endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 6;
  localparam int TYPE_W = 2;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_W  = PC_W - IDX_W - 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fetch_valid_i = 1'b0;
  logic [PC_W-1:0]   fetch_pc_i = '0;
  logic              pred_valid_o;
  logic              pred_hit_o;
  logic              pred_taken_o;
  logic [TYPE_W-1:0] pred_type_o;
  logic [PC_W-1:0]   pred_next_pc_o;
  logic              upd_valid_i = 1'b0;
  logic [PC_W-1:0]   upd_pc_i = '0;
  logic [TYPE_W-1:0] upd_type_i = '0;
  logic [PC_W-1:0]   upd_target_i = '0;
  logic              upd_taken_i = 1'b0;
  logic              upd_fetch_hit_i = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .TYPE_W(TYPE_W)) u_dut (
    .clk (clk), .rst (rst),
    .fetch_valid_i (fetch_valid_i), .fetch_pc_i (fetch_pc_i),
    .pred_valid_o (pred_valid_o), .pred_hit_o (pred_hit_o),
    .pred_taken_o (pred_taken_o), .pred_type_o (pred_type_o),
    .pred_next_pc_o (pred_next_pc_o),
    .upd_valid_i (upd_valid_i), .upd_pc_i (upd_pc_i),
    .upd_type_i (upd_type_i), .upd_target_i (upd_target_i),
    .upd_taken_i (upd_taken_i), .upd_fetch_hit_i (upd_fetch_hit_i)
  );

  typedef struct {
    bit          fv;
    bit          hit;
    bit          taken;
    logic [31:0] nxt;
    logic [1:0]  typ;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;

  // Reference table kept by the bench.
  bit               m_v   [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [1:0]       m_typ [DEPTH];
  logic [31:0]      m_tgt [DEPTH];
  bit               m_out [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [31:0] fpc,
                      input bit uv, input logic [31:0] upc, input logic [1:0] utyp,
                      input logic [31:0] utgt, input bit utaken, input bit uhit,
                      input string req);
    exp_t e;
    int   fi;
    int   ui;
    fetch_valid_i   = fv;
    fetch_pc_i      = fpc;
    upd_valid_i     = uv;
    upd_pc_i        = upc;
    upd_type_i      = utyp;
    upd_target_i    = utgt;
    upd_taken_i     = utaken;
    upd_fetch_hit_i = uhit;
    // expectation from the contents before this cycle's update (R9)
    fi      = int'(fpc[7:2]);
    e.fv    = fv;
    e.hit   = m_v[fi] && (m_tag[fi] == fpc[31:8]);
    e.taken = e.hit && m_out[fi];
    e.nxt   = e.taken ? m_tgt[fi] : fpc + 32'd4;
    e.typ   = e.hit ? m_typ[fi] : 2'd0;
    e.req   = req;
    if (uv) begin
      ui = int'(upc[7:2]);
      if (!uhit) begin
        m_v[ui]   = 1'b1;
        m_tag[ui] = upc[31:8];
        m_typ[ui] = utyp;
        m_tgt[ui] = utgt;
        m_out[ui] = utaken;
      end else if (m_out[ui] != utaken) begin
        m_out[ui] = utaken;
      end
    end
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(1'b1, pc, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 1'b0, req);
  endtask

  task automatic train(input logic [31:0] pc, input logic [1:0] typ, input logic [31:0] tgt,
                       input bit taken, input bit fhit, input string req);
    step(1'b0, 32'h0, 1'b1, pc, typ, tgt, taken, fhit, req);
  endtask

  // Monitor: compares each result against the queued expectation.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(pred_valid_o == e.fv, e.req, "valid", 32'(pred_valid_o), 32'(e.fv));
      if (e.fv) begin
        check(pred_hit_o == e.hit, e.req, "hit", 32'(pred_hit_o), 32'(e.hit));
        check(pred_taken_o == e.taken, e.req, "taken", 32'(pred_taken_o), 32'(e.taken));
        check(pred_next_pc_o == e.nxt, e.req, "next_pc", pred_next_pc_o, e.nxt);
        check(pred_type_o == e.typ, e.req, "type", 32'(pred_type_o), 32'(e.typ));
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_typ[i] = '0; m_tgt[i] = '0; m_out[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 / R6: no result while reset is held
    check(pred_valid_o == 1'b0, "R1", "valid_in_reset", 32'(pred_valid_o), 32'h0);
    rst = 1'b0;

    // R1: empty table after reset
    look(32'h0000_0100, "R1");
    look(32'h0000_0040, "R1");
    // R6: idle cycle gives no result
    step(1'b0, 32'h0, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 1'b0, "R6");

    // R7/R3/R4/R5: fill a taken branch, then a not-taken one
    train(32'h0000_0040, 2'd1, 32'h0000_0200, 1'b1, 1'b0, "R7");
    look(32'h0000_0040, "R5");
    train(32'h0000_0080, 2'd2, 32'h0000_0300, 1'b0, 1'b0, "R7");
    look(32'h0000_0080, "R4");
    // R2: same index, other tag
    look(32'h0000_0140, "R2");
    look(32'h0000_0044, "R3");

    // R8: hit-flag update with new payload only flips the outcome
    train(32'h0000_0040, 2'd3, 32'h0000_0999, 1'b0, 1'b1, "R8");
    look(32'h0000_0040, "R8");
    train(32'h0000_0040, 2'd0, 32'h0000_0777, 1'b1, 1'b1, "R8");
    look(32'h0000_0040, "R8");
    // R11: same outcome again changes nothing
    train(32'h0000_0040, 2'd2, 32'h0000_0555, 1'b1, 1'b1, "R11");
    look(32'h0000_0040, "R11");

    // R10: disabled update with live-looking fields
    step(1'b0, 32'h0, 1'b0, 32'h0000_0080, 2'd3, 32'h0000_0abc, 1'b1, 1'b0, "R10");
    look(32'h0000_0080, "R10");
    step(1'b0, 32'h0, 1'b0, 32'h0000_0100, 2'd3, 32'h0000_0abc, 1'b1, 1'b0, "R10");
    look(32'h0000_0100, "R10");

    // R7/R2: a miss-flag fill evicts the other tag in the slot
    train(32'h0000_0140, 2'd1, 32'h0000_0500, 1'b1, 1'b0, "R7");
    look(32'h0000_0140, "R7");
    look(32'h0000_0040, "R2");

    // R9: lookup and fill of the same slot in one cycle
    step(1'b1, 32'h0000_0080, 1'b1, 32'h0000_0080, 2'd3, 32'h0000_0600, 1'b1, 1'b0, "R9");
    look(32'h0000_0080, "R9");

    // R5: sequential wrap at the top of the address space
    look(32'hFFFF_FFFC, "R5");
    train(32'hFFFF_FFFC, 2'd1, 32'h0000_1000, 1'b1, 1'b0, "R5");
    look(32'hFFFF_FFFC, "R5");

    // R6: back-to-back lookups stream one result per cycle
    look(32'h0000_0040, "R6");
    look(32'h0000_0080, "R6");
    look(32'h0000_0140, "R6");
    look(32'h0000_0200, "R6");

    // R8: a hit update whose fetch flag was stale writes only the outcome
    train(32'h0000_0300, 2'd2, 32'h0000_0880, 1'b1, 1'b1, "R8");
    look(32'h0000_0300, "R8");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule